// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out, pin by pin, the value a GPIO port reports as its input data. It reads the port's configuration registers as inputs: a two-bit mode field, an output-type bit, a two-bit pull field and an output-data bit for each pin. It also takes external stimulus for each pin: a drive strobe with a level, and a disconnect request that carries a pin mask. Each pin has a small link state machine that records whether something outside is driving the pin, and at which level. The machine refuses drives that would fight an active output. After a mode or output-type write, it drops links that now contend with an output.

A second, port-wide machine re-evaluates the input-data word in the cycle after any strobe and registers it. A pin whose resolved level cannot be determined is floating: it keeps its previous value and produces no event. Every determinate change of level gives a one-cycle rise or fall pulse on that pin. Analog and alternate-function modes resolve exactly like input mode. The surrounding register block drives `cfg_wr_i` when it writes the mode or output-type registers, and `data_wr_i` when it writes the pull or output-data registers.

Link states of each pin: `LNK_OPEN` (disconnected), `LNK_LOW` (driven low from outside) and `LNK_HIGH` (driven high from outside). The link transitions are:
- DISC_REQ: any state goes to `LNK_OPEN` when the pin is masked in a disconnect request.
- DRIVE_ACCEPT: any state goes to `LNK_LOW` or `LNK_HIGH`, following the driven level.
- FORCE_DROP: `LNK_LOW` or `LNK_HIGH` goes to `LNK_OPEN` on a contending configuration write.
- REJECT: the state stays where it is and a conflict is flagged.

Evaluation states: `EV_IDLE` and `EV_ARMED`. The transitions are ARM (any strobe moves the machine to `EV_ARMED`) and SETTLE (a cycle with no strobe returns it to `EV_IDLE`). The register updates only while the machine is in `EV_ARMED`.

Top module: `gpio_level_resolver`

## Requirements
- R1: Mode field of pin n is `mode_i[2n+1:2n]`. The value 01 selects output; 00, 10 and 11 all resolve as input.
- R2: An output pin with `otype_i[n]`=0 (push-pull) reads `odata_i[n]`. An output pin with `otype_i[n]`=1 (open-drain) and `odata_i[n]`=0 reads 0.
- R3: An open-drain output pin with `odata_i[n]`=1 reads 0 while it is externally held low. Otherwise it resolves from its pull field `pull_i[2n+1:2n]`: 01 (pull-up) gives 1, 10 (pull-down) gives 0, and 00 or 11 leave it floating, which keeps its previous value.
- R4: An input pin that is externally connected reads its recorded external level. A disconnected input pin reads its pull value, or keeps its previous value when it has no pull.
- R5: A drive on an output pin is rejected unless the pin is open-drain and the driven level is 0. A rejected drive leaves the link state unchanged.
- R6: An accepted drive connects the pin and records the driven level.
- R7: In a cycle with `cfg_wr_i`, a connected output pin that is push-pull, or that is externally held high, is forced to disconnected.
- R8: A disconnect request disconnects every pin set in `disc_mask_i`. It takes priority over a drive on the same pin in the same cycle.
- R9: Reset leaves every pin disconnected, with `idr_o` at 0. The first cycle after reset evaluates `idr_o` from the configuration present then.
- R10: A determinate change of a pin's resolved level from 0 to 1 pulses `rise_o[n]` for one cycle; a change from 1 to 0 pulses `fall_o[n]`. Floating pins pulse neither.
- R11: `idr_o` is re-evaluated and registered only in the cycle after `cfg_wr_i`, `data_wr_i`, `disc_req_i` or an accepted drive. Configuration changes without a strobe leave it unchanged.
- R12: `conflict_o[n]` pulses for exactly the cycle after a rejected drive or a forced disconnect of pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2*PINS | Mode fields, two bits per pin |
| otype_i | input | PINS | Output type, 1 = open-drain |
| pull_i | input | 2*PINS | Pull fields, two bits per pin |
| odata_i | input | PINS | Output data bits |
| cfg_wr_i | input | 1 | Mode or output-type register was written |
| data_wr_i | input | 1 | Pull or output-data register was written |
| drv_vld_i | input | PINS | External drive strobe per pin |
| drv_lvl_i | input | PINS | External drive level per pin |
| disc_req_i | input | 1 | Disconnect request strobe |
| disc_mask_i | input | PINS | Pins to disconnect |
| idr_o | output | PINS | Registered resolved input data |
| rise_o | output | PINS | One-cycle rise event per pin |
| fall_o | output | PINS | One-cycle fall event per pin |
| conflict_o | output | PINS | One-cycle conflict flag per pin |

## Verification
The assertions check these behaviours on every cycle:
- A rejected drive holds the link state, and an accepted drive records its level.
- A disconnect request wins over a drive on the same pin.
- A contending configuration write drops the link and flags a conflict.
- Every edge pulse agrees with the change in `idr_o`.
- `idr_o` never moves outside an armed cycle.

The actual resolved values need the bench's scenarios. These cover push-pull and open-drain outputs, the pull and floating cases, analog mode read as input, the post-reset evaluation, and configuration changes that arrive without a strobe.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

    typedef enum logic [1:0] {
        LNK_OPEN = 2'b00,
        LNK_LOW  = 2'b01,
        LNK_HIGH = 2'b10
    } link_state_e;

    typedef enum logic {
        EV_IDLE  = 1'b0,
        EV_ARMED = 1'b1
    } eval_state_e;

    typedef struct packed {
        logic det;
        logic lvl;
    } pin_res_t;

    localparam logic [1:0] MODE_OUT = 2'b01;
    localparam logic [1:0] PULL_UP  = 2'b01;
    localparam logic [1:0] PULL_DN  = 2'b10;

endpackage

// File: rtl/gpio_pin_link.sv
module gpio_pin_link
    import gpio_res_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        is_out,
    input  logic        is_od,
    input  logic        cfg_wr,
    input  logic        drv_vld,
    input  logic        drv_lvl,
    input  logic        disc_hit,
    output link_state_e state_o,
    output logic        accept_o,
    output logic        conflict_o
);

    link_state_e state_q, state_d;
    logic        drv_ok;
    logic        reject_d, force_d;

    // A drive is acceptable on an input, or as a low level on an open-drain output
    assign drv_ok   = !is_out || (is_od && !drv_lvl);
    assign accept_o = drv_vld && drv_ok && !disc_hit;
    assign state_o  = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_OPEN;
        else        state_q <= state_d;
    end

    // Transitions: DISC_REQ > DRIVE_ACCEPT > REJECT / FORCE_DROP
    always_comb begin
        state_d  = state_q;
        reject_d = 1'b0;
        force_d  = 1'b0;
        if (disc_hit) begin
            state_d = LNK_OPEN;
        end else if (drv_vld && drv_ok) begin
            state_d = drv_lvl ? LNK_HIGH : LNK_LOW;
        end else begin
            reject_d = drv_vld;
            unique case (state_q)
                LNK_OPEN: state_d = LNK_OPEN;
                LNK_LOW: begin
                    if (cfg_wr && is_out && !is_od) begin
                        state_d = LNK_OPEN;
                        force_d = 1'b1;
                    end
                end
                LNK_HIGH: begin
                    if (cfg_wr && is_out) begin
                        state_d = LNK_OPEN;
                        force_d = 1'b1;
                    end
                end
                default: state_d = LNK_OPEN;
            endcase
        end
    end

    // Output register: conflict pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conflict_o <= 1'b0;
        else        conflict_o <= reject_d | force_d;
    end

    // R5: a rejected drive leaves the link untouched and flags a conflict
    a_r5_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vld && !drv_ok && !disc_hit && !cfg_wr) |=> (state_q == $past(state_q)) && conflict_o);

    // R6: an accepted drive records its level
    a_r6_accept_records: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vld && drv_ok && !disc_hit) |=> (state_q == ($past(drv_lvl) ? LNK_HIGH : LNK_LOW)));

    // R8: a disconnect request wins over everything
    a_r8_disc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        disc_hit |=> (state_q == LNK_OPEN));

    // R7: a contending configuration write drops the link
    a_r7_forced_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !disc_hit && !(drv_vld && drv_ok) && is_out &&
         ((state_q == LNK_HIGH) || (state_q == LNK_LOW && !is_od)))
        |=> (state_q == LNK_OPEN) && conflict_o);

endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_res_pkg::*;
(
    input  logic [1:0]  mode_fld,
    input  logic [1:0]  pull_fld,
    input  logic        is_od,
    input  logic        odata,
    input  link_state_e link,
    output pin_res_t    res_o
);

    pin_res_t pull_res;

    // Resolution from the pull field alone: 01 up, 10 down, otherwise floating
    always_comb begin
        unique case (pull_fld)
            PULL_UP: pull_res = '{det: 1'b1, lvl: 1'b1};
            PULL_DN: pull_res = '{det: 1'b1, lvl: 1'b0};
            default: pull_res = '{det: 1'b0, lvl: 1'b0};
        endcase
    end

    always_comb begin
        if (mode_fld == MODE_OUT) begin
            if (!is_od)             res_o = '{det: 1'b1, lvl: odata};
            else if (!odata)        res_o = '{det: 1'b1, lvl: 1'b0};
            else if (link == LNK_LOW) res_o = '{det: 1'b1, lvl: 1'b0};
            else                    res_o = pull_res;
        end else begin
            unique case (link)
                LNK_LOW:  res_o = '{det: 1'b1, lvl: 1'b0};
                LNK_HIGH: res_o = '{det: 1'b1, lvl: 1'b1};
                default:  res_o = pull_res;
            endcase
        end
    end

endmodule

// File: rtl/gpio_level_resolver.sv
module gpio_level_resolver
    import gpio_res_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*PINS-1:0]   mode_i,
    input  logic [PINS-1:0]     otype_i,
    input  logic [2*PINS-1:0]   pull_i,
    input  logic [PINS-1:0]     odata_i,
    input  logic                cfg_wr_i,
    input  logic                data_wr_i,
    input  logic [PINS-1:0]     drv_vld_i,
    input  logic [PINS-1:0]     drv_lvl_i,
    input  logic                disc_req_i,
    input  logic [PINS-1:0]     disc_mask_i,
    output logic [PINS-1:0]     idr_o,
    output logic [PINS-1:0]     rise_o,
    output logic [PINS-1:0]     fall_o,
    output logic [PINS-1:0]     conflict_o
);

    localparam int FW = 2;

    logic [PINS-1:0] accept;
    logic [PINS-1:0] res_det, res_lvl;
    logic [PINS-1:0] idr_d;
    logic            arm;
    eval_state_e     ev_q, ev_d;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        link_state_e link;
        pin_res_t    res;
        logic        out_sel;

        assign out_sel = (mode_i[FW*p +: FW] == MODE_OUT);

        gpio_pin_link u_link (
            .clk        (clk),
            .rst_n      (rst_n),
            .is_out     (out_sel),
            .is_od      (otype_i[p]),
            .cfg_wr     (cfg_wr_i),
            .drv_vld    (drv_vld_i[p]),
            .drv_lvl    (drv_lvl_i[p]),
            .disc_hit   (disc_req_i && disc_mask_i[p]),
            .state_o    (link),
            .accept_o   (accept[p]),
            .conflict_o (conflict_o[p])
        );

        gpio_pin_resolve u_res (
            .mode_fld (mode_i[FW*p +: FW]),
            .pull_fld (pull_i[FW*p +: FW]),
            .is_od    (otype_i[p]),
            .odata    (odata_i[p]),
            .link     (link),
            .res_o    (res)
        );

        assign res_det[p] = res.det;
        assign res_lvl[p] = res.lvl;
    end

    assign arm   = cfg_wr_i | data_wr_i | disc_req_i | (|accept);
    assign idr_d = (res_det & res_lvl) | (~res_det & idr_o);

    // Evaluation state register (armed out of reset: R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= EV_ARMED;
        else        ev_q <= ev_d;
    end

    always_comb begin
        unique case (ev_q)
            EV_IDLE:  ev_d = arm ? EV_ARMED : EV_IDLE;
            EV_ARMED: ev_d = arm ? EV_ARMED : EV_IDLE;
            default:  ev_d = EV_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idr_o  <= '0;
            rise_o <= '0;
            fall_o <= '0;
        end else begin
            unique case (ev_q)
                EV_ARMED: begin
                    idr_o  <= idr_d;
                    rise_o <= res_det &  res_lvl & ~idr_o;
                    fall_o <= res_det & ~res_lvl &  idr_o;
                end
                default: begin
                    rise_o <= '0;
                    fall_o <= '0;
                end
            endcase
        end
    end

    // R10: a rise pulse means the bit went from 0 to 1
    a_r10_rise_true: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |-> (((rise_o & ~idr_o) == '0) && ((rise_o & $past(idr_o)) == '0)));

    // R10: a fall pulse means the bit went from 1 to 0
    a_r10_fall_true: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_o) |-> (((fall_o & idr_o) == '0) && ((fall_o & ~$past(idr_o)) == '0)));

    // R11: the input data only moves after an armed cycle
    a_r11_idr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ev_q == EV_ARMED) |-> $stable(idr_o));

endmodule

// File: tb/gpio_level_resolver_bench.sv
module gpio_level_resolver_bench;

    localparam int N = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n;
    logic [2*N-1:0]  mode, pull;
    logic [N-1:0]    otype, odata, drv_vld, drv_lvl, disc_mask;
    logic            cfg_wr, data_wr, disc_req;
    logic [N-1:0]    idr, rise, fall, conflict;

    gpio_level_resolver #(.PINS(N)) u_gpio_level_resolver (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
        .odata_i(odata), .cfg_wr_i(cfg_wr), .data_wr_i(data_wr), .drv_vld_i(drv_vld),
        .drv_lvl_i(drv_lvl), .disc_req_i(disc_req), .disc_mask_i(disc_mask),
        .idr_o(idr), .rise_o(rise), .fall_o(fall), .conflict_o(conflict)
    );

    typedef struct {
        int           cyc;
        string        req;
        bit           is_conf;
        logic [N-1:0] e_conf, e_idr, e_rise, e_fall;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    bit           m_conn[N];
    bit           m_hi[N];
    logic [N-1:0] m_idr;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops items due this cycle and compares
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc == cyc) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (it.is_conf) begin
                if (conflict !== it.e_conf) begin
                    n_bad++;
                    $display("FAIL %s conflict actual=%h expected=%h", it.req, conflict, it.e_conf);
                end
            end else if (idr !== it.e_idr || rise !== it.e_rise || fall !== it.e_fall) begin
                n_bad++;
                $display("FAIL %s idr/rise/fall actual=%h/%h/%h expected=%h/%h/%h",
                         it.req, idr, rise, fall, it.e_idr, it.e_rise, it.e_fall);
            end
        end
    end

    task automatic set_mode(input int p, input logic [1:0] v);
        mode[2*p +: 2] = v;
    endtask

    task automatic set_pull(input int p, input logic [1:0] v);
        pull[2*p +: 2] = v;
    endtask

    // Driver: applies one stimulus cycle, updates the model, queues expectations
    task automatic op(input bit cw, input bit dw, input logic [N-1:0] dv, input logic [N-1:0] dl,
                      input bit dr, input logic [N-1:0] dm, input string req);
        item_t        a, b;
        logic [N-1:0] e_conf = '0, n_idr, e_r = '0, e_f = '0;
        bit           pend;
        pend = cw | dw | dr;
        for (int i = 0; i < N; i++) begin
            bit o, od;
            o  = (mode[2*i +: 2] == 2'b01);
            od = otype[i];
            if (dr && dm[i]) m_conn[i] = 1'b0;
            else if (dv[i] && (!o || (od && !dl[i]))) begin
                m_conn[i] = 1'b1; m_hi[i] = dl[i]; pend = 1'b1;
            end else begin
                if (dv[i]) e_conf[i] = 1'b1;
                if (cw && m_conn[i] && o && (!od || m_hi[i])) begin
                    m_conn[i] = 1'b0; e_conf[i] = 1'b1;
                end
            end
        end
        n_idr = m_idr;
        if (pend) begin
            for (int i = 0; i < N; i++) begin
                bit det, lvl;
                logic [1:0] pl;
                pl = pull[2*i +: 2];
                det = 1'b1; lvl = 1'b0;
                if (mode[2*i +: 2] == 2'b01 && !otype[i]) lvl = odata[i];
                else if (mode[2*i +: 2] == 2'b01 && !odata[i]) lvl = 1'b0;
                else if (mode[2*i +: 2] == 2'b01 && m_conn[i] && !m_hi[i]) lvl = 1'b0;
                else if (mode[2*i +: 2] != 2'b01 && m_conn[i]) lvl = m_hi[i];
                else if (pl == 2'b01) lvl = 1'b1;
                else if (pl == 2'b10) lvl = 1'b0;
                else det = 1'b0;
                if (det) begin
                    n_idr[i] = lvl;
                    e_r[i] = lvl & ~m_idr[i];
                    e_f[i] = ~lvl & m_idr[i];
                end
            end
        end
        m_idr = n_idr;
        cfg_wr = cw; data_wr = dw; drv_vld = dv; drv_lvl = dl; disc_req = dr; disc_mask = dm;
        a = '{cyc: cyc + 1, req: req, is_conf: 1'b1, e_conf: e_conf, e_idr: '0, e_rise: '0, e_fall: '0};
        b = '{cyc: cyc + 2, req: req, is_conf: 1'b0, e_conf: '0, e_idr: n_idr, e_rise: e_r, e_fall: e_f};
        q.push_back(a);
        q.push_back(b);
        @(negedge clk);
        cfg_wr = 0; data_wr = 0; drv_vld = '0; drv_lvl = '0; disc_req = 0; disc_mask = '0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_cmp++; n_bad++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; mode = '0; pull = '0; otype = '0; odata = '0;
        cfg_wr = 0; data_wr = 0; drv_vld = '0; drv_lvl = '0; disc_req = 0; disc_mask = '0;
        for (int i = 0; i < N; i++) begin m_conn[i] = 0; m_hi[i] = 0; end
        set_pull(0, 2'b01);
        set_pull(1, 2'b10);
        repeat (3) @(negedge clk);
        // R9: held in reset, everything low
        n_cmp++;
        if (idr !== '0 || rise !== '0 || fall !== '0 || conflict !== '0) begin
            n_bad++;
            $display("FAIL R9 reset outputs actual=%h/%h/%h/%h expected=0", idr, rise, fall, conflict);
        end
        rst_n = 1;
        // R9: first cycle after reset evaluates pull-up on pin 0
        m_idr = 16'h0001;
        begin
            item_t r;
            r = '{cyc: cyc + 1, req: "R9", is_conf: 1'b0, e_conf: '0,
                  e_idr: 16'h0001, e_rise: 16'h0001, e_fall: '0};
            q.push_back(r);
        end
        repeat (2) @(negedge clk);

        // R6 R4: input pin 2 driven high, then low
        op(0, 0, 16'h0004, 16'h0004, 0, '0, "R6");
        op(0, 0, 16'h0004, 16'h0000, 0, '0, "R4");
        // R4: disconnect with no pull holds; then pull-up resolves 1
        op(0, 0, '0, '0, 1, 16'h0004, "R4");
        set_pull(2, 2'b01);
        op(0, 1, '0, '0, 0, '0, "R4");
        // R2: pin 3 push-pull output high
        set_mode(3, 2'b01); odata[3] = 1;
        op(1, 0, '0, '0, 0, '0, "R2");
        // R5: drive low on push-pull output is rejected
        op(0, 0, 16'h0008, 16'h0000, 0, '0, "R5");
        // R3: pin 4 open-drain output high, no pull: floating
        set_mode(4, 2'b01); otype[4] = 1; odata[4] = 1;
        op(1, 0, '0, '0, 0, '0, "R3");
        // R6 R3: accepted low drive on open-drain reads 0; high drive rejected
        op(0, 0, 16'h0010, 16'h0000, 0, '0, "R3");
        op(0, 0, 16'h0010, 16'h0010, 0, '0, "R5");
        // R8 R3: disconnect pin 4 and enable pull-up -> 1
        set_pull(4, 2'b01);
        op(0, 0, '0, '0, 1, 16'h0010, "R8");
        // R7 R12: pin 5 input driven high, then made a push-pull output
        op(0, 0, 16'h0020, 16'h0020, 0, '0, "R6");
        set_mode(5, 2'b01); odata[5] = 0;
        op(1, 0, '0, '0, 0, '0, "R7");
        // R1: analog mode (11) behaves as input
        set_mode(6, 2'b11);
        op(0, 0, 16'h0040, 16'h0040, 0, '0, "R1");
        // R8: disconnect request beats a same-cycle drive on pin 7 (pull-down)
        set_pull(7, 2'b10);
        op(0, 0, 16'h0080, 16'h0080, 1, 16'h0080, "R8");
        // R11: output data change without a strobe does nothing; then the strobe applies it
        odata[3] = 0;
        op(0, 0, '0, '0, 0, '0, "R11");
        op(0, 1, '0, '0, 0, '0, "R11");
        // R10: floating pin 8 emits no event while pin 0 pull changes to down
        set_pull(0, 2'b10);
        op(0, 1, '0, '0, 0, '0, "R10");
        // R12: conflict is a single-cycle pulse
        op(0, 0, 16'h0008, 16'h0008, 0, '0, "R12");
        n_cmp++;
        if (conflict !== '0) begin
            n_bad++;
            $display("FAIL R12 conflict width actual=%h expected=0", conflict);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule